// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide register front end of an eight-line programmable interrupt controller. Software talks to it through two byte addresses. Offset 0 carries the command bytes: the start of initialization, end-of-interrupt commands and read-select commands. Offset 1 carries the interrupt mask and the remaining initialization bytes. What a byte written to offset 1 means depends on how far the initialization sequence has progressed.

The block holds the configuration:
- the mask,
- the vector base,
- the cascade map or slave identity,
- the trigger mode,
- the cascade/single choice,
- the automatic end-of-interrupt setting.

It drives all of these to a separate request-resolution core. That core supplies the pending-request and in-service registers back to this block, so software can read them. End-of-interrupt commands leave the block as one-cycle pulses with a line number. Commands for rotation, priority setting and special mask are decoded and then dropped.

The bus is synchronous. A write takes effect at the clock edge where the write strobe is high. Read data appears on the cycle after the read strobe and is held until the next read.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the mask, the cascade map and auto-EOI are zero, the sequence is idle (an offset 1 write loads the mask), and offset 0 reads return the pending-request input.
- R2: An offset 0 write with bit 4 set starts initialization. It clears the mask and sets edge mode from bit 3. It sets cascade mode when bit 1 is 0. It records that a fourth byte will follow when bit 0 is 1.
- R3: The first offset 1 write after initialization starts sets the vector base to the byte with bits 2:0 cleared. In single mode it also clears the cascade output and returns the sequence to idle.
- R4: In cascade mode, the second offset 1 write sets the cascade output. A master stores all 8 bits. A slave stores only bits 2:0, with bits 7:3 read as zero.
- R5: When a fourth byte was requested, the third offset 1 write (in cascade mode) sets auto-EOI from its bit 1 and ends the sequence. Starting initialization without requesting a fourth byte clears auto-EOI.
- R6: An offset 1 write while idle loads the mask. Offset 1 writes during initialization leave the mask unchanged.
- R7: An offset 0 write with bits 4:3 = 00 and bits 7:5 = 001 raises `eoi_ns_o` for exactly one cycle, on the cycle after the write. `eoi_line_o` then carries the index of the highest set bit of `isr_i`, or 0 when none is set.
- R8: An offset 0 write with bits 4:3 = 00 and bits 7:5 = 011 raises `eoi_sp_o` for one cycle, on the cycle after the write, with `eoi_line_o` equal to bits 2:0 of the byte. The two pulses are never high together.
- R9: Offset 0 writes with bits 4:3 = 00 and any other value of bits 7:5 raise no pulse and change no configuration output.
- R10: An offset 0 write with bits 4:3 = 01 and bit 1 set selects what offset 0 reads return: the `irr_i` input when bit 0 = 1, the `isr_i` input when bit 0 = 0. With bit 1 clear, the selection is unchanged.
- R11: An offset 1 read returns the mask. Read data is valid from the cycle after the read strobe and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Byte offset (0 or 1) |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irr_i | input | 8 | Pending-request register from the resolution core |
| isr_i | input | 8 | In-service register from the resolution core |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, bits 2:0 zero |
| casc_o | output | 8 | Slave-present map (master) or slave identity |
| edge_mode_o | output | 1 | 1 = edge triggered, 0 = level |
| casc_mode_o | output | 1 | 1 = cascade mode, 0 = single |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt enabled |
| eoi_ns_o | output | 1 | Non-specific end-of-interrupt pulse |
| eoi_sp_o | output | 1 | Specific end-of-interrupt pulse |
| eoi_line_o | output | 3 | Line number for either pulse |

## Verification
Three initialization sequences are exercised, and each ends with a mask write to show where the sequence stopped:
- Single mode with a fourth byte requested shows that single mode ends the sequence early.
- Cascade mode with a fourth byte shows the full four-step path.
- Cascade mode without a fourth byte shows that auto-EOI is cleared and the sequence stops after three bytes.

A second instance configured as a slave receives the same cascade byte as the master, which separates full-byte storage from identity-only storage. Every end-of-interrupt subcommand code is written in turn. This separates the two codes that pulse from the six that do nothing. The read-select command is issued with its enable bit both set and clear.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  typedef enum logic [1:0] {
    STEP_IDLE,
    STEP_BASE,
    STEP_CASC,
    STEP_MODE
  } step_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_INIT,
    CMD_OP2,
    CMD_OP3
  } cmd_e;

  localparam logic [2:0] OP2_EOI_NS = 3'b001;
  localparam logic [2:0] OP2_EOI_SP = 3'b011;
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_cmd_pkg::*;
(
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [1:0] kind_i,    // command byte bits 4:3
  output cmd_e       cmd_o,
  output logic       cfg_wr_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (wr_i && !addr_i) begin
      if (kind_i[1])       cmd_o = CMD_INIT;
      else if (kind_i[0])  cmd_o = CMD_OP3;
      else                 cmd_o = CMD_OP2;
    end
  end

  assign cfg_wr_o = wr_i && addr_i;
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int DW        = 8,
  parameter int LINE_W    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cmd_e          cmd_i,
  input  logic          cfg_wr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] vec_base_o,
  output logic [DW-1:0] casc_o,
  output logic          edge_mode_o,
  output logic          casc_mode_o,
  output logic          auto_eoi_o
);
  localparam logic [DW-1:0] VEC_KEEP = {{(DW-LINE_W){1'b1}}, {LINE_W{1'b0}}};
  localparam logic [DW-1:0] ID_KEEP  = {{(DW-LINE_W){1'b0}}, {LINE_W{1'b1}}};

  step_e step_q;
  logic  want_mode_q;
  logic [DW-1:0] casc_val;

  generate
    if (IS_MASTER) begin : g_master
      assign casc_val = data_i;
    end else begin : g_slave
      assign casc_val = data_i & ID_KEEP;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q      <= STEP_IDLE;
      want_mode_q <= 1'b0;
      mask_o      <= '0;
      vec_base_o  <= '0;
      casc_o      <= '0;
      edge_mode_o <= 1'b0;
      casc_mode_o <= 1'b0;
      auto_eoi_o  <= 1'b0;
    end else if (cmd_i == CMD_INIT) begin
      mask_o      <= '0;
      edge_mode_o <= data_i[3];
      casc_mode_o <= ~data_i[1];
      want_mode_q <= data_i[0];
      if (!data_i[0]) auto_eoi_o <= 1'b0;
      step_q      <= STEP_BASE;
    end else if (cfg_wr_i) begin
      unique case (step_q)
        STEP_IDLE: mask_o <= data_i;
        STEP_BASE: begin
          vec_base_o <= data_i & VEC_KEEP;
          if (casc_mode_o) begin
            step_q <= STEP_CASC;
          end else begin
            casc_o <= '0;
            step_q <= STEP_IDLE;
          end
        end
        STEP_CASC: begin
          casc_o <= casc_val;
          step_q <= want_mode_q ? STEP_MODE : STEP_IDLE;
        end
        STEP_MODE: begin
          auto_eoi_o <= data_i[1];
          step_q     <= STEP_IDLE;
        end
        default: step_q <= STEP_IDLE;
      endcase
    end
  end

  p_mask_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_INIT |=> mask_o == '0);
  p_vec_base_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_INIT && cfg_wr_i && step_q == STEP_BASE)
      |=> vec_base_o == ($past(data_i) & VEC_KEEP));
  p_single_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_INIT && cfg_wr_i && step_q == STEP_BASE && !casc_mode_o)
      |=> (step_q == STEP_IDLE && casc_o == '0));
  p_mask_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_INIT && cfg_wr_i && step_q != STEP_IDLE) |=> $stable(mask_o));
  p_mode_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_INIT && cfg_wr_i && step_q == STEP_MODE)
      |=> (step_q == STEP_IDLE && auto_eoi_o == $past(data_i[1])));
endmodule

// File: rtl/pic_eoi_gen.sv
module pic_eoi_gen
  import pic_cmd_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  cmd_e                 cmd_i,
  input  logic [2:0]           sub_i,
  input  logic [LINE_W-1:0]    line_i,
  input  logic [NUM_LINES-1:0] isr_i,
  output logic                 eoi_ns_o,
  output logic                 eoi_sp_o,
  output logic [LINE_W-1:0]    eoi_line_o
);
  logic [LINE_W-1:0] top_line;
  logic is_ns, is_sp;

  // highest set in-service bit, 0 when none
  always_comb begin
    top_line = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (isr_i[i]) top_line = LINE_W'(i);
  end

  assign is_ns = (cmd_i == CMD_OP2) && (sub_i == OP2_EOI_NS);
  assign is_sp = (cmd_i == CMD_OP2) && (sub_i == OP2_EOI_SP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoi_ns_o   <= 1'b0;
      eoi_sp_o   <= 1'b0;
      eoi_line_o <= '0;
    end else begin
      eoi_ns_o <= is_ns;
      eoi_sp_o <= is_sp;
      if (is_ns)      eoi_line_o <= top_line;
      else if (is_sp) eoi_line_o <= line_i;
    end
  end

  p_eoi_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eoi_ns_o && eoi_sp_o));
  p_ns_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoi_ns_o) |-> $past(cmd_i == CMD_OP2 && sub_i == OP2_EOI_NS));
  p_sp_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_OP2 && sub_i == OP2_EOI_SP) |=> (eoi_sp_o && eoi_line_o == $past(line_i)));
  p_no_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_OP2 && sub_i != OP2_EOI_NS && sub_i != OP2_EOI_SP)
      |=> (!eoi_ns_o && !eoi_sp_o));
endmodule

// File: rtl/pic_rd_port.sv
module pic_rd_port
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cmd_e          cmd_i,
  input  logic [1:0]    sel_i,   // command byte bits 1:0
  input  logic          rd_i,
  input  logic          addr_i,
  input  logic [DW-1:0] irr_i,
  input  logic [DW-1:0] isr_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] rdata_o
);
  logic sel_irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_irr_q <= 1'b1;
      rdata_o   <= '0;
    end else begin
      if (cmd_i == CMD_OP3 && sel_i[1]) sel_irr_q <= sel_i[0];
      if (rd_i) rdata_o <= addr_i ? mask_i : (sel_irr_q ? irr_i : isr_i);
    end
  end

  p_sel_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_OP3 || !sel_i[1]) |=> $stable(sel_irr_q));
  p_mask_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i) |=> rdata_o == $past(mask_i));
  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
  import pic_cmd_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int NUM_LINES = 8,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] rdata_o,
  input  logic [NUM_LINES-1:0] irr_i,
  input  logic [NUM_LINES-1:0] isr_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] vec_base_o,
  output logic [NUM_LINES-1:0] casc_o,
  output logic                 edge_mode_o,
  output logic                 casc_mode_o,
  output logic                 auto_eoi_o,
  output logic                 eoi_ns_o,
  output logic                 eoi_sp_o,
  output logic [LINE_W-1:0]    eoi_line_o
);
  cmd_e cmd;
  logic cfg_wr;

  pic_cmd_decode u_dec (
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .kind_i   (wdata_i[4:3]),
    .cmd_o    (cmd),
    .cfg_wr_o (cfg_wr)
  );

  pic_init_seq #(
    .IS_MASTER (IS_MASTER),
    .DW        (NUM_LINES),
    .LINE_W    (LINE_W)
  ) u_init (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .cfg_wr_i    (cfg_wr),
    .data_i      (wdata_i),
    .mask_o      (mask_o),
    .vec_base_o  (vec_base_o),
    .casc_o      (casc_o),
    .edge_mode_o (edge_mode_o),
    .casc_mode_o (casc_mode_o),
    .auto_eoi_o  (auto_eoi_o)
  );

  pic_eoi_gen #(
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W)
  ) u_eoi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .sub_i      (wdata_i[7:5]),
    .line_i     (wdata_i[LINE_W-1:0]),
    .isr_i      (isr_i),
    .eoi_ns_o   (eoi_ns_o),
    .eoi_sp_o   (eoi_sp_o),
    .eoi_line_o (eoi_line_o)
  );

  pic_rd_port #(
    .DW (NUM_LINES)
  ) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .sel_i   (wdata_i[1:0]),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .irr_i   (irr_i),
    .isr_i   (isr_i),
    .mask_i  (mask_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: tb/pic_cmd_seq_bench.sv
module pic_cmd_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, irr = '0, isr = '0;
  logic [7:0] rdata, mask, vec, casc, s_rdata, s_mask, s_vec, s_casc;
  logic edge_m, casc_m, aeoi, ns, sp, s_edge, s_cm, s_aeoi, s_ns, s_sp;
  logic [2:0] line, s_line;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic cap_ns, cap_sp;
  logic [2:0] cap_line;

  always #5 clk = ~clk;

  pic_cmd_seq u_pic_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irr_i(irr), .isr_i(isr),
    .mask_o(mask), .vec_base_o(vec), .casc_o(casc), .edge_mode_o(edge_m),
    .casc_mode_o(casc_m), .auto_eoi_o(aeoi), .eoi_ns_o(ns), .eoi_sp_o(sp),
    .eoi_line_o(line)
  );

  pic_cmd_seq #(.IS_MASTER(1'b0)) u_slave (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(s_rdata), .irr_i(irr), .isr_i(isr),
    .mask_o(s_mask), .vec_base_o(s_vec), .casc_o(s_casc), .edge_mode_o(s_edge),
    .casc_mode_o(s_cm), .auto_eoi_o(s_aeoi), .eoi_ns_o(s_ns), .eoi_sp_o(s_sp),
    .eoi_line_o(s_line)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    cap_ns = ns; cap_sp = sp; cap_line = line;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    irr = 8'hA5; isr = 8'h3C;
    chk("R1 mask", mask, 8'h00);
    chk("R1 auto_eoi", aeoi, 0);
    chk("R1 casc", casc, 8'h00);
    bus_rd(1'b0, d);
    chk("R1 read sel irr", d, 8'hA5);
    bus_wr(1'b1, 8'h3C);
    chk("R1 idle mask load", mask, 8'h3C);
    bus_rd(1'b1, d);
    chk("R11 read mask", d, 8'h3C);
    @(negedge clk);
    chk("R11 read hold", rdata, 8'h3C);
  endtask

  task automatic t_single();
    bus_wr(1'b0, 8'h1B);
    chk("R2 mask cleared", mask, 8'h00);
    chk("R2 edge", edge_m, 1);
    chk("R2 single", casc_m, 0);
    bus_wr(1'b1, 8'h47);
    chk("R3 vec base", vec, 8'h40);
    chk("R3 casc cleared", casc, 8'h00);
    chk("R6 mask held in init", mask, 8'h00);
    bus_wr(1'b1, 8'h55);
    chk("R3 single ends seq", mask, 8'h55);
    chk("R3 auto_eoi untouched", aeoi, 0);
  endtask

  task automatic t_cascade();
    bus_wr(1'b0, 8'h11);
    chk("R2 level", edge_m, 0);
    chk("R2 cascade", casc_m, 1);
    bus_wr(1'b1, 8'h20);
    chk("R3 vec base", vec, 8'h20);
    bus_wr(1'b1, 8'hFD);
    chk("R4 master casc", casc, 8'hFD);
    chk("R4 slave id", s_casc, 8'h05);
    chk("R6 mask held", mask, 8'h00);
    bus_wr(1'b1, 8'h03);
    chk("R5 auto_eoi set", aeoi, 1);
    chk("R6 mask held", mask, 8'h00);
    bus_wr(1'b1, 8'h0F);
    chk("R5 seq ended", mask, 8'h0F);
    chk("R5 auto_eoi kept", aeoi, 1);
  endtask

  task automatic t_no_mode();
    bus_wr(1'b0, 8'h10);
    chk("R5 auto_eoi cleared", aeoi, 0);
    bus_wr(1'b1, 8'h08);
    chk("R3 vec", vec, 8'h08);
    bus_wr(1'b1, 8'h04);
    chk("R4 casc", casc, 8'h04);
    bus_wr(1'b1, 8'h77);
    chk("R6 mask after three bytes", mask, 8'h77);
    chk("R5 auto_eoi still clear", aeoi, 0);
  endtask

  task automatic t_eoi();
    isr = 8'h28;
    bus_wr(1'b0, 8'h20);
    chk("R7 ns pulse", cap_ns, 1);
    chk("R7 ns line", cap_line, 5);
    chk("R8 exclusive", cap_sp, 0);
    @(negedge clk);
    chk("R7 one cycle", ns, 0);
    isr = 8'h00;
    bus_wr(1'b0, 8'h20);
    chk("R7 empty isr line", cap_line, 0);
    bus_wr(1'b0, 8'h63);
    chk("R8 sp pulse", cap_sp, 1);
    chk("R8 sp line", cap_line, 3);
    chk("R8 exclusive", cap_ns, 0);
    @(negedge clk);
    chk("R8 one cycle", sp, 0);
    for (int c = 0; c < 8; c++) begin
      if (c == 1 || c == 3) continue;
      bus_wr(1'b0, {c[2:0], 5'b00111});
      chk("R9 no ns", cap_ns, 0);
      chk("R9 no sp", cap_sp, 0);
    end
    chk("R9 mask kept", mask, 8'h77);
    chk("R9 vec kept", vec, 8'h08);
    chk("R9 auto_eoi kept", aeoi, 0);
  endtask

  task automatic t_rdsel();
    logic [7:0] d;
    irr = 8'h81; isr = 8'h42;
    bus_wr(1'b0, 8'h0A);
    bus_rd(1'b0, d);
    chk("R10 select isr", d, 8'h42);
    bus_wr(1'b0, 8'h09);
    bus_rd(1'b0, d);
    chk("R10 bit1 clear keeps", d, 8'h42);
    bus_wr(1'b0, 8'h0B);
    bus_rd(1'b0, d);
    chk("R10 select irr", d, 8'h81);
    bus_rd(1'b1, d);
    chk("R11 mask read", d, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_cascade();
    t_no_mode();
    t_eoi();
    t_rdsel();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule